// File: doc/BRIEF.md
# Banked Block Copy Sequencer

This block copies a run of bytes from one 24-bit address region to another. Each address is an 8-bit bank joined to a 16-bit offset. A start request carries five things: the source bank, the destination bank, two starting offsets (X for the source, Y for the destination) and a count C. The count holds the number of bytes minus one. The engine then walks both offsets and moves one byte per step through a byte-wide memory port with a ready handshake. The block has no memory of its own. The surrounding logic, or the bench, provides it.

Two mode inputs are captured with the start request:

- **Direction.** Ascending mode copies forward. Descending mode starts from the offsets of the last bytes and walks downwards, so that an overlapping copy to a higher address stays correct.
- **Index width.** In narrow mode the offsets are limited to 8 bits, so only the first 256 bytes of each bank can be reached.

When the run ends, the engine presents the final offsets, the final count and the data-bank value on its outputs, and it gives a one-cycle done pulse.

Top module: `blkmov_engine`

## Requirements
- R1: After a synchronous reset, busy, done, mem_rd and mem_wr are low, and x_out, y_out, c_out and db_out are zero.
- R2: A start request taken while idle sets db_out to dst_bank on the next cycle. In that same cycle the first read is issued at address {src_bank, X}, with the bank in bits 23:16 and the offset in bits 15:0. Every write goes to bank db_out.
- R3: Each byte is moved in two phases. First the engine reads the byte at {source bank, X}. It then writes the same byte to {db_out, Y}. mem_rd and mem_wr are never high together.
- R4: When dir_down is 0, X and Y each increase by one after every byte is written. When dir_down is 1, they each decrease by one.
- R5: Exactly c_in + 1 bytes are moved. The run ends after the write that wraps the count from 0 to 0xFFFF, so c_out reads 0xFFFF at the end.
- R6: When narrow_idx is 1, the upper byte of each offset is forced to zero when the offsets are loaded. Each step then wraps within 8 bits, so the accesses never leave the first 256 bytes of their bank.
- R7: In wide mode a 16-bit offset wraps from 0xFFFF to 0x0000, or from 0x0000 to 0xFFFF, and never carries into or borrows from the bank.
- R8: With mem_ready held high, one byte takes BYTE_CYCLES clock cycles (7 by default). That is one read cycle, one write cycle, then BYTE_CYCLES-2 idle cycles before the next read.
- R9: While mem_ready is low, the current strobe, address and write data stay unchanged until mem_ready is high at a clock edge.
- R10: done is high for exactly one cycle, the cycle after the last write is accepted, and busy stays high through that cycle. busy is low on the following cycle.
- R11: A start request that arrives while busy is high has no effect on the run in progress or on its final values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Starts a run when the engine is idle |
| dir_down | input | 1 | 0 copies in ascending order, 1 in descending order |
| narrow_idx | input | 1 | 1 limits the offsets to 8 bits |
| src_bank | input | 8 | Source bank |
| dst_bank | input | 8 | Destination bank |
| x_in | input | 16 | Source offset at start |
| y_in | input | 16 | Destination offset at start |
| c_in | input | 16 | Byte count minus one |
| mem_addr | output | 24 | Memory address, bank in bits 23:16 |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, taken when mem_ready is high |
| mem_ready | input | 1 | Completes the current read or write |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| x_out | output | 16 | Current source offset |
| y_out | output | 16 | Current destination offset |
| c_out | output | 16 | Current count |
| db_out | output | 8 | Data bank, equal to the destination bank |

## Verification
Every internal register of this engine shows up at the ports within a single step. A bad offset or bank appears on mem_addr at the next strobe. A wrong count moves done by a whole BYTE_CYCLES period or more. A lost or extra pad cycle moves the next read strobe by one cycle. A latch error in the data path shows up as wrong mem_wdata in the write cycle that follows the read. For this reason the bench compares every output on every clock, which pins each fault to the cycle it appears in. At the end of each run it also checks the destination bytes in its memory.

// File: rtl/blkmov_pkg.sv
`timescale 1ns/1ps
package blkmov_pkg;

    parameter int OFS_W    = 16;
    parameter int BANK_W   = 8;
    parameter int DATA_W   = 8;
    parameter int NARROW_W = 8;
    parameter int ADDR_W   = BANK_W + OFS_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_WRITE,
        PH_PAD,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [OFS_W-1:0]  x;
        logic [OFS_W-1:0]  y;
        logic [OFS_W-1:0]  c;
        logic [BANK_W-1:0] db;
        logic [BANK_W-1:0] sb;
        logic              down;
        logic              narrow;
    } ctx_t;

    // Clear the upper bits of an offset when only the narrow index is in use.
    function automatic logic [OFS_W-1:0] clip_ofs(input logic [OFS_W-1:0] v,
                                                  input logic narrow);
        logic [OFS_W-1:0] r;
        r = v;
        if (narrow) r[OFS_W-1:NARROW_W] = '0;
        return r;
    endfunction

    // Move an offset one step. It wraps inside its own width and never reaches the bank.
    function automatic logic [OFS_W-1:0] step_ofs(input logic [OFS_W-1:0] v,
                                                  input logic down,
                                                  input logic narrow);
        logic [OFS_W-1:0] n;
        n = down ? v - 1'b1 : v + 1'b1;
        return clip_ofs(n, narrow);
    endfunction

endpackage

// File: rtl/blkmov_seq.sv
`timescale 1ns/1ps
module blkmov_seq
    import blkmov_pkg::*;
#(
    parameter int BYTE_CYCLES = 7
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start_req,
    input  logic   mem_ready,
    input  logic   last,
    output phase_e phase,
    output logic   load,
    output logic   rd_ack,
    output logic   wr_ack
);

    localparam int PADS     = (BYTE_CYCLES > 2) ? BYTE_CYCLES - 2 : 0;
    localparam int PAD_W    = (PADS > 1) ? $clog2(PADS) : 1;
    localparam int PAD_LOAD = (PADS > 0) ? PADS - 1 : 0;

    phase_e           ph_q, ph_d;
    logic [PAD_W-1:0] pad_q;
    logic             pad_end;

    assign phase   = ph_q;
    assign load    = (ph_q == PH_IDLE)  && start_req;
    assign rd_ack  = (ph_q == PH_READ)  && mem_ready;
    assign wr_ack  = (ph_q == PH_WRITE) && mem_ready;
    assign pad_end = (pad_q == '0);

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE:  if (start_req) ph_d = PH_READ;
            PH_READ:  if (mem_ready) ph_d = PH_WRITE;
            PH_WRITE: begin
                if (mem_ready) begin
                    if (last)          ph_d = PH_DONE;
                    else if (PADS > 0) ph_d = PH_PAD;
                    else               ph_d = PH_READ;
                end
            end
            PH_PAD:   if (pad_end) ph_d = PH_READ;
            PH_DONE:  ph_d = PH_IDLE;
            default:  ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            pad_q <= '0;
        end else begin
            ph_q <= ph_d;
            if (wr_ack)
                pad_q <= PAD_W'(PAD_LOAD);
            else if (ph_q == PH_PAD && !pad_end)
                pad_q <= pad_q - 1'b1;
        end
    end

endmodule

// File: rtl/blkmov_ctx.sv
`timescale 1ns/1ps
module blkmov_ctx
    import blkmov_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic [BANK_W-1:0] src_bank,
    input  logic [BANK_W-1:0] dst_bank,
    input  logic [OFS_W-1:0]  x_in,
    input  logic [OFS_W-1:0]  y_in,
    input  logic [OFS_W-1:0]  c_in,
    input  logic              down,
    input  logic              narrow,
    output ctx_t              ctx,
    output logic              last
);

    ctx_t ctx_q;

    assign ctx  = ctx_q;
    assign last = (ctx_q.c == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else if (load) begin
            ctx_q.x      <= clip_ofs(x_in, narrow);
            ctx_q.y      <= clip_ofs(y_in, narrow);
            ctx_q.c      <= c_in;
            ctx_q.db     <= dst_bank;
            ctx_q.sb     <= src_bank;
            ctx_q.down   <= down;
            ctx_q.narrow <= narrow;
        end else if (advance) begin
            ctx_q.x <= step_ofs(ctx_q.x, ctx_q.down, ctx_q.narrow);
            ctx_q.y <= step_ofs(ctx_q.y, ctx_q.down, ctx_q.narrow);
            ctx_q.c <= ctx_q.c - 1'b1;
        end
    end

endmodule

// File: rtl/blkmov_port.sv
`timescale 1ns/1ps
module blkmov_port
    import blkmov_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  ctx_t              ctx,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata
);

    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst)         data_q <= '0;
        else if (rd_ack) data_q <= mem_rdata;
    end

    always_comb begin
        mem_rd   = (phase == PH_READ);
        mem_wr   = (phase == PH_WRITE);
        mem_addr = '0;
        if (mem_rd)      mem_addr = {ctx.sb, ctx.x};
        else if (mem_wr) mem_addr = {ctx.db, ctx.y};
    end

    assign mem_wdata = data_q;

endmodule

// File: rtl/blkmov_engine.sv
`timescale 1ns/1ps
module blkmov_engine
    import blkmov_pkg::*;
#(
    parameter int BYTE_CYCLES = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              dir_down,
    input  logic              narrow_idx,
    input  logic [BANK_W-1:0] src_bank,
    input  logic [BANK_W-1:0] dst_bank,
    input  logic [OFS_W-1:0]  x_in,
    input  logic [OFS_W-1:0]  y_in,
    input  logic [OFS_W-1:0]  c_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic [OFS_W-1:0]  x_out,
    output logic [OFS_W-1:0]  y_out,
    output logic [OFS_W-1:0]  c_out,
    output logic [BANK_W-1:0] db_out
);

    phase_e phase;
    ctx_t   ctx_q;
    logic   load, rd_ack, wr_ack, last;

    blkmov_seq #(.BYTE_CYCLES(BYTE_CYCLES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .mem_ready (mem_ready),
        .last      (last),
        .phase     (phase),
        .load      (load),
        .rd_ack    (rd_ack),
        .wr_ack    (wr_ack)
    );

    blkmov_ctx u_ctx (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .advance  (wr_ack),
        .src_bank (src_bank),
        .dst_bank (dst_bank),
        .x_in     (x_in),
        .y_in     (y_in),
        .c_in     (c_in),
        .down     (dir_down),
        .narrow   (narrow_idx),
        .ctx      (ctx_q),
        .last     (last)
    );

    blkmov_port u_port (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .ctx       (ctx_q),
        .rd_ack    (rd_ack),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata)
    );

    assign busy   = (phase != PH_IDLE);
    assign done   = (phase == PH_DONE);
    assign x_out  = ctx_q.x;
    assign y_out  = ctx_q.y;
    assign c_out  = ctx_q.c;
    assign db_out = ctx_q.db;

endmodule

// File: rtl/blkmov_engine_chk.sv
`timescale 1ns/1ps
module blkmov_engine_chk
    import blkmov_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [OFS_W-1:0]  x_out,
    input logic [OFS_W-1:0]  c_out,
    input logic [BANK_W-1:0] db_out,
    input logic              narrow_run
);

    assert_no_dual_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_write_bank_R2: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_addr[ADDR_W-1:OFS_W] == db_out));

    assert_offset_moves_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_ready) |=> (x_out != $past(x_out)));

    assert_end_count_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (c_out == '1));

    assert_narrow_page_R6: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && narrow_run) |-> (mem_addr[OFS_W-1:NARROW_W] == '0));

    assert_read_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    assert_write_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> busy ##1 (!done && !busy));

    assert_bank_kept_R11: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(db_out)));

endmodule

bind blkmov_engine blkmov_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .x_out      (x_out),
    .c_out      (c_out),
    .db_out     (db_out),
    .narrow_run (ctx_q.narrow)
);

// File: tb/blkmov_engine_test.sv
`timescale 1ns/1ps
module blkmov_engine_test;

    localparam int BYTE_CYCLES = 7;
    localparam int PAD_CYC     = BYTE_CYCLES - 2;
    localparam int WATCHDOG    = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_req = 1'b0, dir_down = 1'b0, narrow_idx = 1'b0;
    logic [7:0]  src_bank = '0, dst_bank = '0;
    logic [15:0] x_in = '0, y_in = '0, c_in = '0;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic [23:0] mem_addr;
    logic        mem_rd, mem_wr, busy, done;
    logic [7:0]  mem_wdata, db_out;
    logic [15:0] x_out, y_out, c_out;

    always #2.5 clk = ~clk;

    blkmov_engine #(.BYTE_CYCLES(BYTE_CYCLES)) uut (
        .clk(clk), .rst(rst), .start_req(start_req), .dir_down(dir_down),
        .narrow_idx(narrow_idx), .src_bank(src_bank), .dst_bank(dst_bank),
        .x_in(x_in), .y_in(y_in), .c_in(c_in), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .done(done),
        .x_out(x_out), .y_out(y_out), .c_out(c_out), .db_out(db_out)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit finished = 0;
    logic [7:0] mem [int];

    // reference model state
    int          ph = 0, pad = 0;
    logic [15:0] mx = 0, my = 0, mc = 0;
    logic [7:0]  mdb = 0, msb = 0, mdata = 0;
    logic        mdown = 0, mnarrow = 0;
    int          ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit          pend_start = 0;

    function automatic logic [7:0] fill(int a);
        logic [31:0] u;
        u = a;
        return (u[7:0] * 8'd37) ^ u[15:8] ^ u[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] mrd(int a);
        if (mem.exists(a)) return mem[a];
        return fill(a);
    endfunction

    function automatic logic [15:0] tb_step(logic [15:0] v, logic down, logic narrow);
        int n;
        n = down ? int'(v) - 1 : int'(v) + 1;
        n = narrow ? (n & 'hFF) : (n & 'hFFFF);
        return n[15:0];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // per-cycle compare, stimulus and model update, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            check("R10 busy", busy, ph != 0);
            check("R10 done", done, ph == 4);
            check("R3 read strobe (R8 spacing)", mem_rd, ph == 1);
            check("R3 write strobe", mem_wr, ph == 2);
            if (ph == 1) check("R2 read address", mem_addr, {msb, mx});
            if (ph == 2) begin
                check("R3 write address", mem_addr, {mdb, my});
                check("R3 write data", mem_wdata, mdata);
            end
            check("R4 x_out", x_out, mx);
            check("R4 y_out", y_out, my);
            check("R5 c_out", c_out, mc);
            check("R2 db_out", db_out, mdb);
        end
        if (cyc > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            finish_run();
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready = (ready_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
        start_req = pend_start;
        pend_start = 0;
        mem_rdata = mrd(int'(mem_addr));
        if (mem_wr && mem_ready) mem[int'(mem_addr)] = mem_wdata;
        rst = (cyc < 4);
        if (rst) begin
            ph = 0; pad = 0; mx = 0; my = 0; mc = 0; mdb = 0; msb = 0; mdata = 0;
        end else begin
            case (ph)
                0: if (start_req) begin
                    mx = narrow_idx ? {8'h00, x_in[7:0]} : x_in;
                    my = narrow_idx ? {8'h00, y_in[7:0]} : y_in;
                    mc = c_in; mdb = dst_bank; msb = src_bank;
                    mdown = dir_down; mnarrow = narrow_idx; ph = 1;
                end
                1: if (mem_ready) begin mdata = mem_rdata; ph = 2; end
                2: if (mem_ready) begin
                    mx = tb_step(mx, mdown, mnarrow);
                    my = tb_step(my, mdown, mnarrow);
                    if (mc == 0) ph = 4;
                    else begin ph = 3; pad = PAD_CYC; end
                    mc = mc - 1'b1;
                end
                3: begin pad--; if (pad == 0) ph = 1; end
                default: ph = 0;
            endcase
        end
    end

    task automatic run_case(string tag, logic down, logic narrow, logic [7:0] sb,
                            logic [7:0] db, logic [15:0] x, logic [15:0] y,
                            logic [15:0] c, int rmode, bit poke);
        int          ea [$];
        logic [7:0]  ev [$];
        logic [15:0] so, dof;
        int          t;
        so  = narrow ? {8'h00, x[7:0]} : x;
        dof = narrow ? {8'h00, y[7:0]} : y;
        for (int i = 0; i <= int'(c); i++) begin
            ea.push_back(int'({db, dof}));
            ev.push_back(mrd(int'({sb, so})));
            so  = tb_step(so, down, narrow);
            dof = tb_step(dof, down, narrow);
        end
        dir_down = down; narrow_idx = narrow; src_bank = sb; dst_bank = db;
        x_in = x; y_in = y; c_in = c; ready_mode = rmode;
        pend_start = 1;
        repeat (3) @(posedge clk);
        if (poke) begin
            // R11: a second request mid-run with other values must be ignored
            repeat (8) @(posedge clk);
            dst_bank = db ^ 8'hFF; x_in = 16'h7777; y_in = 16'h8888; c_in = 16'h0100;
            dir_down = ~down; pend_start = 1;
        end
        t = 0;
        while (!done && t < 20000) begin @(posedge clk); t++; end
        repeat (3) @(posedge clk);
        check({tag, " final count"}, c_out, 16'hFFFF);
        check({tag, " final bank"}, db_out, db);
        check({tag, " engine idle"}, busy, 1'b0);
        foreach (ea[i]) check({tag, " destination byte"}, mrd(ea[i]), ev[i]);
    endtask

    initial begin
        wait (!rst);
        repeat (3) @(posedge clk);
        // R1 is covered by the first per-cycle compare after reset (model all zero)
        run_case("R5 ascending",          0, 0, 8'h12, 8'h34, 16'h1000, 16'h2000, 16'd4, 0, 0);
        run_case("R4 descending ready",   1, 0, 8'h21, 8'h43, 16'h2003, 16'h3003, 16'd3, 1, 0);
        run_case("R6 narrow wrap",        0, 1, 8'h05, 8'h06, 16'h01FE, 16'h0340, 16'd3, 0, 0);
        run_case("R7 wide wrap up",       0, 0, 8'h07, 8'h08, 16'hFFFE, 16'h4000, 16'd3, 1, 0);
        run_case("R7 wide wrap down",     1, 0, 8'h09, 8'h0A, 16'h5003, 16'h0001, 16'd3, 0, 0);
        run_case("R11 start while busy",  0, 0, 8'h0B, 8'h0C, 16'h6000, 16'h6100, 16'd5, 0, 1);
        run_case("R5 single byte",        0, 0, 8'h0D, 8'h0E, 16'h0042, 16'h0084, 16'd0, 1, 0);
        run_case("R6 narrow down",        1, 1, 8'h0F, 8'h10, 16'hAB01, 16'hCD02, 16'd3, 1, 0);
        repeat (5) @(posedge clk);
        finish_run();
    end

endmodule